// File: doc/BRIEF.md
# Single-Bit Test-and-Modify Unit

This unit picks one bit out of a data word, reports whether that bit was clear, and optionally rewrites it. A request carries a 32-bit operand, a bit number, one of four operations (probe only, force high, force low, flip) and a width select that confines the operation either to the low byte or to the full word. The zero indication always describes the bit as it stood before the operation. Software can therefore test a flag and update it in a single request.

Requests enter through a valid/ready handshake. Each accepted request produces exactly one registered result on the output side, one cycle later. The output side has its own valid/ready pair. While downstream back-pressure holds a result, the unit keeps that result and refuses new requests. Operand fetch, write-back and every other status flag belong to the surrounding datapath.

Top module: `bitop_unit`

## Requirements
- R1: With `in_op` = 2'b00 (probe), `out_data` equals the accepted operand unchanged.
- R2: With `in_op` = 2'b01 (force high), `out_data` equals the operand with the selected bit set to 1 and all other bits unchanged.
- R3: With `in_op` = 2'b10 (force low), `out_data` equals the operand with the selected bit set to 0 and all other bits unchanged.
- R4: With `in_op` = 2'b11 (flip), `out_data` equals the operand with the selected bit inverted and all other bits unchanged.
- R5: For every operation, `out_zero` is 1 when the selected bit of the accepted operand was 0, and 0 when it was 1.
- R6: With `in_size` = 0 (byte), only `in_bitnum[2:0]` selects the bit and `in_bitnum[4:3]` are ignored. With `in_size` = 1 (word), all five bits of `in_bitnum` select among bits 0 to 31.
- R7: With `in_size` = 0 (byte), `out_data[31:8]` always equals the operand's bits 31:8.
- R8: A request accepted on a clock edge (`in_valid` and `in_ready` both high) gives `out_valid` high with its result from the following cycle on.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and `out_zero` hold their values and `in_ready` is low.
- R10: After a clock edge with `rst_n` low, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Unit can take a request this cycle |
| in_data | input | 32 | Operand |
| in_bitnum | input | 5 | Bit number |
| in_op | input | 2 | 00 probe, 01 force high, 10 force low, 11 flip |
| in_size | input | 1 | 0 byte, 1 word |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Downstream takes the result this cycle |
| out_data | output | 32 | Operand after the operation |
| out_zero | output | 1 | 1 when the selected bit was 0 before the operation |

## Verification
The hardest case to reach from the ports is a request that is waiting while an earlier result is stalled. Here the unit must keep the old result steady and must not take in the pending request until downstream drains. The stimulus toggles `out_ready` from a pseudo-random pattern while the driver presents requests back to back. Stalls then fall at every phase of the handshake, and on each stalled cycle the bench compares the output against the value of the cycle before. Byte requests use bit numbers above 7 and operands with busy upper bytes, so that both the folding of the bit number and the pass-through of the upper bits show at the output.

// File: rtl/bitop_pkg.sv
// Shared types for the single-bit test-and-modify unit.
// Assumes the operation and width codes below are fixed by the requirements.
package bitop_pkg;

    typedef enum logic [1:0] {
        OP_PROBE = 2'b00,
        OP_FORCE1 = 2'b01,
        OP_FORCE0 = 2'b10,
        OP_FLIP  = 2'b11
    } bitop_op_e;

    typedef enum logic {
        SZ_BYTE = 1'b0,
        SZ_WORD = 1'b1
    } bitop_size_e;

endpackage

// File: rtl/bitop_index.sv
// Turns a bit number and width select into a one-hot bit mask.
// Byte width folds the bit number to its low bits; word width uses it whole.
// Assumes DATA_W and BYTE_W are powers of two with BYTE_W <= DATA_W.
module bitop_index
    import bitop_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int BYTE_W = 8,
    localparam int IDX_W  = $clog2(DATA_W),
    localparam int BIDX_W = $clog2(BYTE_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  bitnum,
    input  bitop_size_e       size,
    output logic [IDX_W-1:0]  idx,
    output logic [DATA_W-1:0] mask
);

    // Fold the bit number according to the width select.
    always_comb begin
        if (size == SZ_WORD) begin
            idx = bitnum;
        end else begin
            idx = {{(IDX_W-BIDX_W){1'b0}}, bitnum[BIDX_W-1:0]};
        end
    end

    // One decoder comparator per data bit.
    for (genvar g = 0; g < DATA_W; g++) begin : g_mask
        assign mask[g] = (idx == IDX_W'(g));
    end

    // R6
    one_bit_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(mask) == 1);

    // R7
    byte_mask_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (size == SZ_BYTE) |-> (mask[DATA_W-1:BYTE_W] == '0));

endmodule

// File: rtl/bitop_modify.sv
// Tests the masked bit of the operand and applies the selected operation.
// Assumes mask is one-hot; the zero flag reflects the bit before modification.
module bitop_modify
    import bitop_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] opnd,
    input  logic [DATA_W-1:0] mask,
    input  bitop_op_e         op,
    input  bitop_size_e       size,
    output logic [DATA_W-1:0] res,
    output logic              zero
);

    logic was_set;

    // Sample the selected bit before any change.
    always_comb begin
        was_set = |(opnd & mask);
        zero    = ~was_set;
    end

    // Apply the chosen operation to the selected bit only.
    always_comb begin
        unique case (op)
            OP_PROBE:  res = opnd;
            OP_FORCE1: res = opnd | mask;
            OP_FORCE0: res = opnd & ~mask;
            OP_FLIP:   res = opnd ^ mask;
            default:   res = opnd;
        endcase
    end

    // R1
    probe_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_PROBE) |-> (res == opnd));

    // R2
    force1_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_FORCE1) |-> ((res & mask) == mask));

    // R3
    force0_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_FORCE0) |-> ((res & mask) == '0));

    // R4
    flip_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_FLIP) |-> (((res ^ opnd) == mask)));

    // R7
    byte_upper_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (size == SZ_BYTE) |-> (res[DATA_W-1:BYTE_W] == opnd[DATA_W-1:BYTE_W]));

endmodule

// File: rtl/bitop_stage.sv
// Single output register with valid/ready on both sides.
// Takes a request when empty or when the held result leaves this cycle.
module bitop_stage #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] nxt_data,
    input  logic              nxt_zero,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data,
    output logic              out_zero
);

    logic              vld_q;
    logic [DATA_W-1:0] data_q;
    logic              zero_q;
    logic              take;

    // Space exists when nothing is held or the held result drains now.
    always_comb begin
        in_ready = !vld_q || out_ready;
        take     = in_valid && in_ready;
    end

    // Track whether a result is held.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= 1'b0;
        end else if (take) begin
            vld_q <= 1'b1;
        end else if (out_ready) begin
            vld_q <= 1'b0;
        end
    end

    // Capture the computed result on acceptance only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
            zero_q <= 1'b0;
        end else if (take) begin
            data_q <= nxt_data;
            zero_q <= nxt_zero;
        end
    end

    assign out_valid = vld_q;
    assign out_data  = data_q;
    assign out_zero  = zero_q;

    // R8
    accept_then_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> out_valid);

    // R9
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_zero)));

    // R10
    reset_empty_chk: assert property (@(posedge clk)
        !rst_n |=> !out_valid);

endmodule

// File: rtl/bitop_unit.sv
// Top of the single-bit test-and-modify unit: index decode, modify, output register.
// Assumes the requester holds its request stable until in_ready accepts it.
module bitop_unit
    import bitop_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int BYTE_W = 8,
    localparam int IDX_W = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    input  logic [IDX_W-1:0]  in_bitnum,
    input  logic [1:0]        in_op,
    input  logic              in_size,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data,
    output logic              out_zero
);

    bitop_op_e         op;
    bitop_size_e       size;
    logic [IDX_W-1:0]  idx;
    logic [DATA_W-1:0] mask;
    logic [DATA_W-1:0] res;
    logic              zero;

    // Map raw port codes to the shared enums.
    always_comb begin
        op   = bitop_op_e'(in_op);
        size = bitop_size_e'(in_size);
    end

    bitop_index #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_index (
        .clk    (clk),
        .rst_n  (rst_n),
        .bitnum (in_bitnum),
        .size   (size),
        .idx    (idx),
        .mask   (mask)
    );

    bitop_modify #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_modify (
        .clk   (clk),
        .rst_n (rst_n),
        .opnd  (in_data),
        .mask  (mask),
        .op    (op),
        .size  (size),
        .res   (res),
        .zero  (zero)
    );

    bitop_stage #(.DATA_W(DATA_W)) u_stage (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .nxt_data  (res),
        .nxt_zero  (zero),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_data  (out_data),
        .out_zero  (out_zero)
    );

    // R5
    zero_matches_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> (out_zero == !$past(in_data[idx])));

endmodule

// File: tb/test_bitop_unit.sv
// Scoreboard bench: the driver queues expected results, the monitor compares them.
module test_bitop_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_data = '0;
    logic [4:0]  in_bitnum = '0;
    logic [1:0]  in_op = '0;
    logic        in_size = 1'b0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [31:0] out_data;
    logic        out_zero;

    typedef struct {
        logic [31:0] d;
        logic        z;
        string       tag;
    } exp_t;

    exp_t exp_q[$];
    int   errors = 0;
    int   checks = 0;
    int   ready_mode = 0;   // 0 always ready, 1 pseudo-random
    bit   done = 1'b0;

    always #4 clk = ~clk;

    bitop_unit i_bitop_unit (
        .clk, .rst_n, .in_valid, .in_ready, .in_data, .in_bitnum, .in_op,
        .in_size, .out_valid, .out_ready, .out_data, .out_zero
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive one request and queue its expected result when it is accepted.
    task automatic send(input logic [31:0] d, input logic [4:0] n, input logic [1:0] op, input logic sz);
        exp_t e;
        int   k;
        bit   orig;
        k    = sz ? int'(n) : int'(n[2:0]);
        orig = d[k];
        e.d  = d;
        case (op)
            2'b00: e.tag = "R1";
            2'b01: begin e.d[k] = 1'b1;  e.tag = "R2"; end
            2'b10: begin e.d[k] = 1'b0;  e.tag = "R3"; end
            default: begin e.d[k] = ~orig; e.tag = "R4"; end
        endcase
        if (!sz) e.tag = {e.tag, "/R6/R7"};
        e.z = ~orig;
        @(negedge clk);
        in_valid  = 1'b1;
        in_data   = d;
        in_bitnum = n;
        in_op     = op;
        in_size   = sz;
        #1;
        while (!in_ready) begin
            @(negedge clk);
            #1;
        end
        exp_q.push_back(e);
        @(negedge clk);
        in_valid = 1'b0;
        // R8: result present one cycle after acceptance
        check(out_valid === 1'b1, "R8 out_valid after accept", 32'(out_valid), 32'd1);
    endtask

    // Monitor: choose out_ready, then compare results that transfer at the next edge.
    initial begin : monitor
        logic [31:0] held_d;
        logic        held_z;
        bit          was_stalled;
        was_stalled = 1'b0;
        forever begin
            @(negedge clk);
            out_ready = (ready_mode == 0) ? 1'b1 : 1'($urandom_range(0, 2) != 0);
            #2;
            if (rst_n && was_stalled) begin
                // R9: held result stays put while stalled
                check(out_valid === 1'b1 && out_data === held_d && out_zero === held_z,
                      "R9 hold under stall", out_data, held_d);
            end
            was_stalled = 1'b0;
            if (rst_n && out_valid === 1'b1 && !out_ready) begin
                // R9: requests blocked while stalled
                check(in_ready === 1'b0, "R9 in_ready low under stall", 32'(in_ready), 32'd0);
                was_stalled = 1'b1;
                held_d = out_data;
                held_z = out_zero;
            end
            if (rst_n && out_valid === 1'b1 && out_ready) begin
                exp_t e;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R8 unexpected result", out_data, '0);
                end else begin
                    e = exp_q.pop_front();
                    check(out_data === e.d, {e.tag, " data"}, out_data, e.d);
                    // R5: zero flag from the original bit
                    check(out_zero === e.z, {e.tag, "/R5 zero"}, 32'(out_zero), 32'(e.z));
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R10: reset state
        check(out_valid === 1'b0, "R10 out_valid in reset", 32'(out_valid), 32'd0);
        check(in_ready === 1'b1, "R10 in_ready in reset", 32'(in_ready), 32'd1);
        rst_n = 1'b1;

        send(32'h0000_0010, 5'd4,  2'b00, 1'b1);   // R1 probe set bit
        send(32'hFFFF_FFEF, 5'd4,  2'b00, 1'b1);   // R1 probe clear bit
        send(32'h0000_0000, 5'd31, 2'b01, 1'b1);   // R2 top bit
        send(32'hFFFF_FFFF, 5'd0,  2'b10, 1'b1);   // R3 bottom bit
        send(32'h1234_5678, 5'd17, 2'b11, 1'b1);   // R4 flip
        send(32'hA5A5_A500, 5'd13, 2'b01, 1'b0);   // R6 13 folds to 5, R7 upper kept
        send(32'hFFFF_FF20, 5'd29, 2'b10, 1'b0);   // R6 29 folds to 5
        send(32'h8000_0000, 5'd31, 2'b11, 1'b0);   // R7 byte flip of bit 7, upper kept
        send(32'h0000_0080, 5'd15, 2'b00, 1'b0);   // R6 15 folds to 7

        ready_mode = 1;
        for (int i = 0; i < 400; i++) begin
            send($urandom, 5'($urandom_range(0, 31)), 2'($urandom_range(0, 3)),
                 1'($urandom_range(0, 1)));
        end

        ready_mode = 0;
        repeat (10) @(negedge clk);
        check(exp_q.size() == 0, "R8 all results delivered", 32'(exp_q.size()), 32'd0);

        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        // R10: reset empties the output
        check(out_valid === 1'b0 && in_ready === 1'b1, "R10 after reset",
              {30'd0, out_valid, in_ready}, 32'd1);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule